// File: doc/BRIEF.md
# Supervisory Power Mode Sequencer

This block is the operating-mode state machine of a supervisory controller that powers a host microcontroller and a bus interface. After power is applied, or after any event that resets the system, it holds an active-low reset output to the host for a lengthened time. It then waits for the host to initialise the watchdog. If initialisation succeeds, the block enters an operating mode. If it fails, the block grants one retry with the longest reset. A second failure parks the block in a latched low-power safe mode. Only a wake request can release that safe mode.

Watchdog behaviour, regulator health and oscillator health come from outside the block as flags and strobes. All durations are counted in ticks of a slow enable input, nominally 1 kHz. With that tick the defaults are 20 ms for a short reset, 140 ms for a long reset, 50 ms for the safe-mode restart delay and 32 ms for the interrupt-response timeout. A 3-bit reset-source code records why the most recent reset was asserted, so that start-up software can take different paths for different causes.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst_n` is low, `mode` reads 0 (Start-up), `rst_out_n` is low and `rst_src` reads 0 (power-on). After `rst_n` is released, the reset output stays low for exactly LONG_TICKS ticks.
- R2: Each later entry into Start-up holds `rst_out_n` low for LONG_TICKS ticks when `long_rst_cfg` is 1 and for SHORT_TICKS ticks when it is 0. This is one cycle longer than the tick count, because the entry edge itself counts.
- R3: In Start-up with the reset released, a `wd_init_ok` strobe enters mode 3 (Normal) when `flash_sel` is 0 and mode 4 (Flash) when it is 1. `rst_out_n` is high in both operating modes.
- R4: In Start-up with the reset released, a `wd_init_fail` strobe enters mode 1 (Restart) and sets `rst_src` to 4 (start failure). The reset is held for LONG_TICKS ticks whatever the value of `long_rst_cfg`.
- R5: In Restart, `wd_init_ok` always enters mode 3, even when `flash_sel` is 1. The block instead enters mode 2 (Fail-safe) with `rst_src` 4 if `wd_init_fail` arrives after the reset is released, or if `vreg_ok` is low when the Restart hold ends.
- R6: Fail-safe keeps `rst_out_n` low and is latched. A wake request on `wake_bus` or `wake_pin` is ignored while `osc_ok` is low.
- R7: A wake request while `osc_ok` is high keeps mode 2 for FS_DELAY_TICKS further ticks. The block then enters Start-up with `rst_src` 3 (wake from Fail-safe).
- R8: A `wd_fault` strobe in mode 3 or mode 4 enters Start-up on the next clock and sets `rst_src` to 1 (watchdog fault).
- R9: In an operating mode, if `irq_pending` is held without `irq_ack` for IRQ_TMO_TICKS ticks, the block enters Start-up with `rst_src` 2 (interrupt timeout). Each `irq_ack` restarts the count.
- R10: When a watchdog fault and an interrupt timeout occur in the same cycle, the watchdog fault wins and `rst_src` is 1.
- R11: Every duration advances only on cycles where `tick` is high. While `tick` is low, the reset hold does not progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | Timebase enable, one cycle per tick |
| wake_bus | input | 1 | Wake request from the bus line |
| wake_pin | input | 1 | Wake request from the local pin |
| osc_ok | input | 1 | On-chip oscillator is good |
| vreg_ok | input | 1 | Main regulator is up |
| wd_init_ok | input | 1 | Strobe: watchdog initialised correctly |
| wd_init_fail | input | 1 | Strobe: watchdog initialisation failed |
| wd_fault | input | 1 | Strobe: watchdog service fault |
| irq_pending | input | 1 | Interrupt to the host is outstanding |
| irq_ack | input | 1 | Host acknowledges the interrupt |
| long_rst_cfg | input | 1 | Selects the long reset for Start-up entries |
| flash_sel | input | 1 | Selects Flash rather than Normal after start-up |
| rst_out_n | output | 1 | Reset to the host, active low |
| rst_src | output | 3 | Cause of the latest reset |
| mode | output | 3 | Current mode: 0 Start-up, 1 Restart, 2 Fail-safe, 3 Normal, 4 Flash |

## Verification
In an operating mode, a watchdog fault and the expiry of the interrupt-response timeout can both request a reset on the same edge. The bench raises `irq_pending` and waits exactly IRQ_TMO_TICKS cycles, which brings the timeout to the point of firing. It then strobes `wd_fault` so that both requests reach the state machine on the same clock. The result passes only if `rst_src` reads 1 and the reset hold has the length that `long_rst_cfg` selects. The same vector table also fires each of the two causes on its own.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

   typedef enum logic [2:0] {
      MODE_STARTUP  = 3'd0,
      MODE_RESTART  = 3'd1,
      MODE_FAILSAFE = 3'd2,
      MODE_NORMAL   = 3'd3,
      MODE_FLASH    = 3'd4
   } mode_e;

   typedef enum logic [2:0] {
      SRC_POWERON    = 3'd0,
      SRC_WDOG       = 3'd1,
      SRC_IRQ_TMO    = 3'd2,
      SRC_WAKE       = 3'd3,
      SRC_START_FAIL = 3'd4
   } rsrc_e;

   typedef enum logic [2:0] {
      ST_SU_HOLD,
      ST_SU_WAIT,
      ST_RS_HOLD,
      ST_RS_WAIT,
      ST_FS_IDLE,
      ST_FS_DELAY,
      ST_RUN_NORMAL,
      ST_RUN_FLASH
   } state_e;

endpackage

// File: rtl/pms_tick_timer.sv
// Tick-paced down counter. It is reloaded when a state is entered and
// reports expiry once it has reached zero.
module pms_tick_timer #(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned INIT  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             expired
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= CNT_W'(INIT);
      else if (load)
         cnt <= load_val;
      else if (tick && cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/pms_irq_guard.sv
// Counts ticks while an interrupt is left unacknowledged in an operating mode.
module pms_irq_guard #(
   parameter int unsigned TMO_TICKS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic armed,
   input  logic irq_pending,
   input  logic irq_ack,
   output logic timeout
);

   localparam int unsigned IW = $clog2(TMO_TICKS + 1);

   logic [IW-1:0] icnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         icnt <= '0;
      else if (!armed || !irq_pending || irq_ack)
         icnt <= '0;
      else if (tick && icnt != IW'(TMO_TICKS))
         icnt <= icnt + 1'b1;
   end

   assign timeout = (icnt == IW'(TMO_TICKS));

endmodule

// File: rtl/pms_mode_fsm.sv
module pms_mode_fsm
   import pwr_mode_pkg::*;
#(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SHORT_TICKS = 20,
   parameter int unsigned LONG_TICKS  = 140,
   parameter int unsigned FSD_TICKS   = 50,
   parameter bit          FLASH_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tmr_expired,
   input  logic             irq_timeout,
   input  logic             wake_bus,
   input  logic             wake_pin,
   input  logic             osc_ok,
   input  logic             vreg_ok,
   input  logic             wd_init_ok,
   input  logic             wd_init_fail,
   input  logic             wd_fault,
   input  logic             long_rst_cfg,
   input  logic             flash_sel,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output state_e           state,
   output rsrc_e            rst_src,
   output logic             operating
);

   state_e     state_nxt, run_target;
   rsrc_e      src_nxt;
   logic [CNT_W-1:0] start_len;

   generate
      if (FLASH_EN) begin : g_flash
         assign run_target = flash_sel ? ST_RUN_FLASH : ST_RUN_NORMAL;
      end else begin : g_noflash
         assign run_target = ST_RUN_NORMAL;
      end
   endgenerate

   assign start_len = long_rst_cfg ? CNT_W'(LONG_TICKS) : CNT_W'(SHORT_TICKS);
   assign operating = (state == ST_RUN_NORMAL) || (state == ST_RUN_FLASH);

   always_comb begin
      state_nxt = state;
      src_nxt   = rst_src;
      tmr_load  = 1'b0;
      tmr_val   = start_len;
      unique case (state)
         ST_SU_HOLD:
            if (tmr_expired) state_nxt = ST_SU_WAIT;
         ST_SU_WAIT:
            if (wd_init_ok) begin
               state_nxt = run_target;
            end else if (wd_init_fail) begin
               state_nxt = ST_RS_HOLD;
               src_nxt   = SRC_START_FAIL;
               tmr_load  = 1'b1;
               tmr_val   = CNT_W'(LONG_TICKS);
            end
         ST_RS_HOLD:
            if (tmr_expired) begin
               if (vreg_ok) begin
                  state_nxt = ST_RS_WAIT;
               end else begin
                  state_nxt = ST_FS_IDLE;
                  src_nxt   = SRC_START_FAIL;
               end
            end
         ST_RS_WAIT:
            if (wd_init_ok) begin
               state_nxt = ST_RUN_NORMAL;
            end else if (wd_init_fail) begin
               state_nxt = ST_FS_IDLE;
               src_nxt   = SRC_START_FAIL;
            end
         ST_FS_IDLE:
            if ((wake_bus || wake_pin) && osc_ok) begin
               state_nxt = ST_FS_DELAY;
               tmr_load  = 1'b1;
               tmr_val   = CNT_W'(FSD_TICKS);
            end
         ST_FS_DELAY:
            if (tmr_expired) begin
               state_nxt = ST_SU_HOLD;
               src_nxt   = SRC_WAKE;
               tmr_load  = 1'b1;
            end
         ST_RUN_NORMAL, ST_RUN_FLASH:
            if (wd_fault) begin
               state_nxt = ST_SU_HOLD;
               src_nxt   = SRC_WDOG;
               tmr_load  = 1'b1;
            end else if (irq_timeout) begin
               state_nxt = ST_SU_HOLD;
               src_nxt   = SRC_IRQ_TMO;
               tmr_load  = 1'b1;
            end
         default: state_nxt = ST_SU_HOLD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_SU_HOLD;
         rst_src <= SRC_POWERON;
      end else begin
         state   <= state_nxt;
         rst_src <= src_nxt;
      end
   end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
   import pwr_mode_pkg::*;
#(
   parameter int unsigned SHORT_TICKS   = 20,
   parameter int unsigned LONG_TICKS    = 140,
   parameter int unsigned FSD_TICKS     = 50,
   parameter int unsigned IRQ_TMO_TICKS = 32,
   parameter bit          FLASH_EN      = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       wake_bus,
   input  logic       wake_pin,
   input  logic       osc_ok,
   input  logic       vreg_ok,
   input  logic       wd_init_ok,
   input  logic       wd_init_fail,
   input  logic       wd_fault,
   input  logic       irq_pending,
   input  logic       irq_ack,
   input  logic       long_rst_cfg,
   input  logic       flash_sel,
   output logic       rst_out_n,
   output logic [2:0] rst_src,
   output logic [2:0] mode
);

   localparam int unsigned MAX_CNT = (LONG_TICKS > FSD_TICKS) ? LONG_TICKS : FSD_TICKS;
   localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);

   generate
      if (SHORT_TICKS == 0 || LONG_TICKS < SHORT_TICKS) begin : g_bad_len
         $error("reset lengths: need 0 < SHORT_TICKS <= LONG_TICKS");
      end
      if (FSD_TICKS == 0 || IRQ_TMO_TICKS == 0) begin : g_bad_delay
         $error("delay and timeout tick counts must be non-zero");
      end
   endgenerate

   state_e           state;
   rsrc_e            src_q;
   logic             tmr_load, tmr_expired, irq_timeout, operating;
   logic [CNT_W-1:0] tmr_val, tmr_cnt;

   pms_tick_timer #(.CNT_W(CNT_W), .INIT(LONG_TICKS)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (tmr_load),
      .load_val (tmr_val),
      .cnt      (tmr_cnt),
      .expired  (tmr_expired)
   );

   pms_irq_guard #(.TMO_TICKS(IRQ_TMO_TICKS)) u_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .armed       (operating),
      .irq_pending (irq_pending),
      .irq_ack     (irq_ack),
      .timeout     (irq_timeout)
   );

   pms_mode_fsm #(
      .CNT_W       (CNT_W),
      .SHORT_TICKS (SHORT_TICKS),
      .LONG_TICKS  (LONG_TICKS),
      .FSD_TICKS   (FSD_TICKS),
      .FLASH_EN    (FLASH_EN)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .tmr_expired  (tmr_expired),
      .irq_timeout  (irq_timeout),
      .wake_bus     (wake_bus),
      .wake_pin     (wake_pin),
      .osc_ok       (osc_ok),
      .vreg_ok      (vreg_ok),
      .wd_init_ok   (wd_init_ok),
      .wd_init_fail (wd_init_fail),
      .wd_fault     (wd_fault),
      .long_rst_cfg (long_rst_cfg),
      .flash_sel    (flash_sel),
      .tmr_load     (tmr_load),
      .tmr_val      (tmr_val),
      .state        (state),
      .rst_src      (src_q),
      .operating    (operating)
   );

   always_comb begin
      unique case (state)
         ST_SU_HOLD, ST_SU_WAIT:   mode = MODE_STARTUP;
         ST_RS_HOLD, ST_RS_WAIT:   mode = MODE_RESTART;
         ST_FS_IDLE, ST_FS_DELAY:  mode = MODE_FAILSAFE;
         ST_RUN_NORMAL:            mode = MODE_NORMAL;
         ST_RUN_FLASH:             mode = MODE_FLASH;
         default:                  mode = MODE_STARTUP;
      endcase
   end

   assign rst_out_n = (state == ST_SU_WAIT) || (state == ST_RS_WAIT) || operating;
   assign rst_src   = src_q;

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned LONG_TICKS = 140
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wd_fault,
   input logic             irq_timeout,
   input logic             rst_out_n,
   input logic [2:0]       rst_src,
   input logic [2:0]       mode,
   input logic [CNT_W-1:0] tmr_cnt
);

   logic run;
   assign run = (mode == 3'd3) || (mode == 3'd4);

   p_failsafe_rst_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd2) |-> !rst_out_n);

   p_run_rst_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> rst_out_n);

   p_failsafe_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == 3'd2 && mode != 3'd2) |-> (mode == 3'd0 && rst_src == 3'd3));

   p_restart_long_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd1 && $past(mode) != 3'd1) |-> (tmr_cnt == CNT_W'(LONG_TICKS) && rst_src == 3'd4));

   p_wdog_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && wd_fault) |=> (mode == 3'd0 && rst_src == 3'd1));

   p_irq_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && irq_timeout && !wd_fault) |=> (mode == 3'd0 && rst_src == 3'd2));

endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.CNT_W(CNT_W), .LONG_TICKS(LONG_TICKS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wd_fault    (wd_fault),
   .irq_timeout (irq_timeout),
   .rst_out_n   (rst_out_n),
   .rst_src     (rst_src),
   .mode        (mode),
   .tmr_cnt     (tmr_cnt)
);

// File: tb/pwr_mode_seq_bench.sv
module pwr_mode_seq_bench;

   localparam int SHORT = 3;
   localparam int LONG  = 6;
   localparam int FSD   = 4;
   localparam int IRQ   = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0, tick = 1'b1;
   logic wake_bus = 1'b0, wake_pin = 1'b0, osc_ok = 1'b1, vreg_ok = 1'b1;
   logic wd_init_ok = 1'b0, wd_init_fail = 1'b0, wd_fault = 1'b0;
   logic irq_pending = 1'b0, irq_ack = 1'b0, long_rst_cfg = 1'b0, flash_sel = 1'b0;
   logic       rst_out_n;
   logic [2:0] rst_src, mode;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   pwr_mode_seq #(
      .SHORT_TICKS(SHORT), .LONG_TICKS(LONG), .FSD_TICKS(FSD), .IRQ_TMO_TICKS(IRQ), .FLASH_EN(1'b1)
   ) u_pwr_mode_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wake_bus(wake_bus), .wake_pin(wake_pin),
      .osc_ok(osc_ok), .vreg_ok(vreg_ok), .wd_init_ok(wd_init_ok), .wd_init_fail(wd_init_fail),
      .wd_fault(wd_fault), .irq_pending(irq_pending), .irq_ack(irq_ack),
      .long_rst_cfg(long_rst_cfg), .flash_sel(flash_sel),
      .rst_out_n(rst_out_n), .rst_src(rst_src), .mode(mode)
   );

   // {kind[1:0], cfg_long, flash, exp_src[2:0]}; kind 0 wdog, 1 irq timeout, 2 both together
   localparam logic [6:0] VEC [5] = '{
      {2'd0, 1'b0, 1'b0, 3'd1},
      {2'd1, 1'b1, 1'b1, 3'd2},
      {2'd2, 1'b0, 1'b0, 3'd1},
      {2'd0, 1'b1, 1'b1, 3'd1},
      {2'd1, 1'b0, 1'b0, 3'd2}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic count_low(output int n);
      n = 0;
      for (int k = 0; k < 1000; k++) begin
         @(negedge clk);
         if (rst_out_n) break;
         n++;
      end
   endtask

   task automatic wait_low(output int n);
      n = 0;
      for (int k = 0; k < 1000; k++) begin
         @(negedge clk);
         if (!rst_out_n) break;
         n++;
      end
   endtask

   task automatic init_ok();
      wd_init_ok = 1'b1;
      @(negedge clk);
      wd_init_ok = 1'b0;
   endtask

   task automatic init_fail();
      wd_init_fail = 1'b1;
      @(negedge clk);
      wd_init_fail = 1'b0;
   endtask

   initial begin
      #(100000 * 20);
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      summary();
   end

   initial begin
      int n;
      int bad;
      repeat (3) @(negedge clk);
      chk("R1 reset rst_out_n", rst_out_n, 0);
      chk("R1 reset mode", mode, 0);
      chk("R1 reset src", rst_src, 0);
      rst_n = 1'b1;
      count_low(n);
      chk("R1 power-on hold", n, LONG);
      chk("R3 start-up wait mode", mode, 0);

      // R4: first start-up failure
      long_rst_cfg = 1'b0;
      init_fail();
      chk("R4 restart mode", mode, 1);
      chk("R4 restart src", rst_src, 4);
      count_low(n);
      chk("R4 forced long hold", n, LONG);
      flash_sel = 1'b1;
      init_ok();
      chk("R5 restart ok goes Normal", mode, 3);
      flash_sel = 1'b0;

      // Vector table: R8 R9 R10 R2 R3
      for (int i = 0; i < 5; i++) begin
         logic [1:0] kind;
         int exp_len;
         kind = VEC[i][6:5];
         long_rst_cfg = VEC[i][4];
         flash_sel = VEC[i][3];
         exp_len = VEC[i][4] ? LONG : SHORT;
         if (kind == 2'd0) begin
            wd_fault = 1'b1;
            @(negedge clk);
            wd_fault = 1'b0;
            chk("R8 wdog reset immediate", rst_out_n, 0);
         end else if (kind == 2'd1) begin
            irq_pending = 1'b1;
            wait_low(n);
            irq_pending = 1'b0;
            chk("R9 irq timeout cycles", n, IRQ);
         end else begin
            irq_pending = 1'b1;
            repeat (IRQ) @(negedge clk);
            chk("R10 no reset before timeout", rst_out_n, 1);
            wd_fault = 1'b1;
            @(negedge clk);
            wd_fault = 1'b0;
            irq_pending = 1'b0;
            chk("R10 collision reset", rst_out_n, 0);
         end
         chk("R8 R9 R10 reset source", rst_src, int'(VEC[i][2:0]));
         chk("R2 start-up mode", mode, 0);
         count_low(n);
         chk("R2 hold length", n, exp_len);
         init_ok();
         chk("R3 operating mode", mode, VEC[i][3] ? 4 : 3);
      end

      // R9: acknowledges keep restarting the window
      bad = 0;
      irq_pending = 1'b1;
      for (int k = 0; k < 15; k++) begin
         @(negedge clk);
         irq_ack = (k % 3 == 2);
         if (!rst_out_n) bad++;
      end
      irq_pending = 1'b0;
      irq_ack = 1'b0;
      chk("R9 ack prevents reset", bad, 0);

      // R11: no tick, no progress
      long_rst_cfg = 1'b0;
      tick = 1'b0;
      wd_fault = 1'b1;
      @(negedge clk);
      wd_fault = 1'b0;
      bad = 0;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (rst_out_n) bad++;
      end
      chk("R11 hold frozen without tick", bad, 0);
      tick = 1'b1;
      count_low(n);
      chk("R11 hold resumes", n, SHORT);

      // R5: restart then second failure
      init_fail();
      count_low(n);
      init_fail();
      chk("R5 second failure fail-safe", mode, 2);
      chk("R5 fail-safe src", rst_src, 4);

      // R6: wake ignored without oscillator
      osc_ok = 1'b0;
      wake_bus = 1'b1;
      @(negedge clk);
      wake_bus = 1'b0;
      repeat (20) @(negedge clk);
      chk("R6 latched mode", mode, 2);
      chk("R6 reset low", rst_out_n, 0);

      // R7: wake with oscillator good
      osc_ok = 1'b1;
      long_rst_cfg = 1'b1;
      wake_pin = 1'b1;
      n = 0;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         wake_pin = 1'b0;
         if (mode != 3'd2) break;
         n++;
      end
      chk("R7 restart delay", n, FSD + 1);
      chk("R7 start-up mode", mode, 0);
      chk("R7 wake src", rst_src, 3);
      count_low(n);
      chk("R7 hold after wake", n, LONG);

      // R5: regulator down at end of Restart hold
      vreg_ok = 1'b0;
      init_fail();
      chk("R5 restart entered", mode, 1);
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         if (mode != 3'd1) break;
      end
      chk("R5 regulator fail to fail-safe", mode, 2);
      chk("R5 regulator fail src", rst_src, 4);
      summary();
   end

endmodule